// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This execution unit sits beside the integer pipeline of a 64-bit core. It holds the two 64-bit product registers, HI and LO, and updates them from two multiply-accumulate instructions. Each cycle it may receive a 32-bit instruction word with a valid strobe, together with the two 64-bit source operand values that the register file has already read. The unit decodes the word. If the word matches one of the two encodings, the unit multiplies the low 32-bit words of the operands as signed numbers and folds the 64-bit product into the registers on the next clock edge.

The plain accumulate form treats the low words of HI and LO as one 64-bit accumulator: HI supplies the upper half and LO the lower half. The doubleword form adds the product to all 64 bits of LO and leaves HI alone. Both HI and LO are visible at all times. A direct load port, standing in for move-to-HI/LO, writes either register for setup.

Top module: `hilo_mac_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `hi_q` and `lo_q` to zero.
- R2: An instruction is recognised only when bits 31:26 are 000000, bits 15:6 are all zero, and bits 5:0 are 101000 (accumulate) or 101001 (doubleword accumulate). Bits 25:16 name the source registers and do not affect decode.
- R3: On accumulate, the value {HI[31:0], LO[31:0]} plus the signed product of `src_a[31:0]` and `src_b[31:0]` is written back. Its upper 32 bits go to HI[31:0] and its lower 32 bits go to LO[31:0]. HI[63:32] and LO[63:32] keep their values.
- R4: On doubleword accumulate, LO becomes LO plus the sign-extended 64-bit signed product, and HI is unchanged.
- R5: When `insn_valid` is low, or the word matches neither encoding, HI and LO keep their values.
- R6: Bits 63:32 of `src_a` and `src_b` have no effect on the result.
- R7: The outputs change only at the first rising edge after the cycle in which the valid instruction is presented.
- R8: `hi_wr_en` loads `wr_data` into HI and `lo_wr_en` loads `wr_data` into LO. In a register that an instruction also targets in the same cycle, the direct load wins. The other register still takes the instruction's result.
- R9: All sums wrap modulo 2^64, with no saturation. The most negative 32-bit value squared gives 2^62.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Instruction word to decode |
| src_a | input | 64 | First source operand value |
| src_b | input | 64 | Second source operand value |
| hi_wr_en | input | 1 | Load `wr_data` into HI |
| lo_wr_en | input | 1 | Load `wr_data` into LO |
| wr_data | input | 64 | Direct load data |
| hi_q | output | 64 | Current HI register |
| lo_q | output | 64 | Current LO register |

## Verification
The assertions check the following on every cycle:
- the decode never flags both operations at once, and never flags a word with nonzero opcode or middle bits;
- the accumulate updates the joined low halves by exactly the product and keeps the upper halves of HI and LO;
- the doubleword form adds the product to LO and leaves HI steady;
- direct loads land in the next cycle;
- reset yields zeros.

Only the bench scenarios can show that the product itself is right for signed corner operands, such as the most negative value squared or a negative times a positive. The same holds for the carry across the HI/LO seam, wraparound at 2^64, operand upper bits being ignored, and the exact cycle of update. To do this, the bench compares each result with its own reference model.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam int OPC_W = 6;
  localparam int FN_W = 6;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
  localparam logic [FN_W-1:0]  FN_ACC      = 6'b101000;
  localparam logic [FN_W-1:0]  FN_DACC     = 6'b101001;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ACC  = 2'd1,
    OP_DACC = 2'd2
  } mac_op_e;

  typedef struct packed {
    logic [XLEN-1:0] hi;
    logic [XLEN-1:0] lo;
  } hilo_t;

  // Sign-extend a half word to full width.
  function automatic logic [XLEN-1:0] widen_signed(input logic [HALF-1:0] h);
    return {{HALF{h[HALF-1]}}, h};
  endfunction

  // Signed product of two half words, exact in XLEN bits.
  function automatic logic [XLEN-1:0] signed_product(input logic [HALF-1:0] a,
                                                     input logic [HALF-1:0] b);
    logic [XLEN-1:0] wa, wb;
    wa = widen_signed(a);
    wb = widen_signed(b);
    return wa * wb;
  endfunction

  // Accumulator view formed from the low halves of HI and LO.
  function automatic logic [XLEN-1:0] joined_acc(input logic [XLEN-1:0] hi,
                                                 input logic [XLEN-1:0] lo);
    return {hi[HALF-1:0], lo[HALF-1:0]};
  endfunction

  // Accumulate into the joined low halves; upper halves stay put.
  function automatic hilo_t acc_update(input logic [XLEN-1:0] hi,
                                       input logic [XLEN-1:0] lo,
                                       input logic [XLEN-1:0] prod);
    hilo_t r;
    logic [XLEN-1:0] sum;
    sum  = joined_acc(hi, lo) + prod;
    r.hi = {hi[XLEN-1:HALF], sum[XLEN-1:HALF]};
    r.lo = {lo[XLEN-1:HALF], sum[HALF-1:0]};
    return r;
  endfunction

  // Doubleword accumulate into LO only.
  function automatic logic [XLEN-1:0] dacc_update(input logic [XLEN-1:0] lo,
                                                  input logic [XLEN-1:0] prod);
    return lo + prod;
  endfunction

endpackage

// File: rtl/mac_op_decode.sv
module mac_op_decode
  import hilo_mac_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] word,
  output mac_op_e     op,
  output logic        is_acc,
  output logic        is_dacc
);

  logic shell_ok;
  logic unused_regfields;

  assign unused_regfields = ^word[25:16];
  assign shell_ok = (word[31:26] == OPC_SPECIAL) && (word[15:6] == '0);

  always_comb begin
    op = OP_NONE;
    if (valid && shell_ok) begin
      if (word[5:0] == FN_ACC)       op = OP_ACC;
      else if (word[5:0] == FN_DACC) op = OP_DACC;
    end
  end

  assign is_acc  = (op == OP_ACC);
  assign is_dacc = (op == OP_DACC);

  always_comb begin
    assert_excl_R2: assert ($onehot0({is_acc, is_dacc}));
    if (is_acc || is_dacc)
      assert_shell_R2: assert (word[31:26] == '0 && word[15:6] == '0 && valid);
  end

endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier
  import hilo_mac_pkg::*;
#(
  parameter bit USE_ARRAY = 1'b0
) (
  input  logic [HALF-1:0] a,
  input  logic [HALF-1:0] b,
  output logic [XLEN-1:0] prod
);

  generate
    if (USE_ARRAY) begin : g_array
      // Shift-add over sign-extended operands, exact modulo 2^XLEN.
      logic [XLEN-1:0] ax, bx;
      logic [XLEN-1:0] psum [0:XLEN];
      assign ax = widen_signed(a);
      assign bx = widen_signed(b);
      assign psum[0] = '0;
      for (genvar i = 0; i < XLEN; i++) begin : g_row
        assign psum[i+1] = psum[i] + (bx[i] ? (ax << i) : '0);
      end
      assign prod = psum[XLEN];
    end else begin : g_op
      assign prod = signed_product(a, b);
    end
  endgenerate

endmodule

// File: rtl/mac_accum_path.sv
module mac_accum_path
  import hilo_mac_pkg::*;
(
  input  mac_op_e         op,
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] lo,
  input  logic [XLEN-1:0] prod,
  output logic [XLEN-1:0] hi_next,
  output logic [XLEN-1:0] lo_next,
  output logic            hi_touch,
  output logic            lo_touch
);

  hilo_t acc_res;

  always_comb begin
    acc_res  = acc_update(hi, lo, prod);
    hi_next  = hi;
    lo_next  = lo;
    hi_touch = 1'b0;
    lo_touch = 1'b0;
    unique case (op)
      OP_ACC: begin
        hi_next  = acc_res.hi;
        lo_next  = acc_res.lo;
        hi_touch = 1'b1;
        lo_touch = 1'b1;
      end
      OP_DACC: begin
        lo_next  = dacc_update(lo, prod);
        lo_touch = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hilo_regfile.sv
module hilo_regfile
  import hilo_mac_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            hi_ld,
  input  logic            lo_ld,
  input  logic [XLEN-1:0] hi_d,
  input  logic [XLEN-1:0] lo_d,
  output logic [XLEN-1:0] hi_r,
  output logic [XLEN-1:0] lo_r
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_r <= '0;
      lo_r <= '0;
    end else begin
      if (hi_ld) hi_r <= hi_d;
      if (lo_ld) lo_r <= lo_d;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hi_r == '0 && lo_r == '0));

  assert_hi_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !hi_ld |=> $stable(hi_r));

  assert_lo_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !lo_ld |=> $stable(lo_r));

endmodule

// File: rtl/hilo_mac_unit.sv
module hilo_mac_unit
  import hilo_mac_pkg::*;
#(
  parameter bit USE_ARRAY_MUL = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            insn_valid,
  input  logic [31:0]     insn_word,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            hi_wr_en,
  input  logic            lo_wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] hi_q,
  output logic [XLEN-1:0] lo_q
);

  mac_op_e         op;
  logic            acc_fire, dacc_fire;
  logic [XLEN-1:0] prod;
  logic [XLEN-1:0] hi_next, lo_next;
  logic            hi_touch, lo_touch;
  logic            hi_load, lo_load;
  logic [XLEN-1:0] hi_d, lo_d;
  logic            accept;
  logic            unused_src_upper;

  assign accept = insn_valid && !rst;
  assign unused_src_upper = ^{src_a[XLEN-1:HALF], src_b[XLEN-1:HALF]};

  mac_op_decode u_dec (
    .valid   (accept),
    .word    (insn_word),
    .op      (op),
    .is_acc  (acc_fire),
    .is_dacc (dacc_fire)
  );

  mac_multiplier #(.USE_ARRAY(USE_ARRAY_MUL)) u_mul (
    .a    (src_a[HALF-1:0]),
    .b    (src_b[HALF-1:0]),
    .prod (prod)
  );

  mac_accum_path u_path (
    .op       (op),
    .hi       (hi_q),
    .lo       (lo_q),
    .prod     (prod),
    .hi_next  (hi_next),
    .lo_next  (lo_next),
    .hi_touch (hi_touch),
    .lo_touch (lo_touch)
  );

  // Direct loads take priority per register.
  assign hi_load = hi_wr_en || hi_touch;
  assign lo_load = lo_wr_en || lo_touch;
  assign hi_d    = hi_wr_en ? wr_data : hi_next;
  assign lo_d    = lo_wr_en ? wr_data : lo_next;

  hilo_regfile u_regs (
    .clk   (clk),
    .rst   (rst),
    .hi_ld (hi_load),
    .lo_ld (lo_load),
    .hi_d  (hi_d),
    .lo_d  (lo_d),
    .hi_r  (hi_q),
    .lo_r  (lo_q)
  );

  assert_acc_sum_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_fire && !hi_wr_en && !lo_wr_en) |=>
      ({hi_q[HALF-1:0], lo_q[HALF-1:0]} ==
       $past({hi_q[HALF-1:0], lo_q[HALF-1:0]}) + $past(prod)));

  assert_acc_upper_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_fire && !hi_wr_en && !lo_wr_en) |=>
      (hi_q[XLEN-1:HALF] == $past(hi_q[XLEN-1:HALF]) &&
       lo_q[XLEN-1:HALF] == $past(lo_q[XLEN-1:HALF])));

  assert_dacc_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (dacc_fire && !lo_wr_en) |=> (lo_q == $past(lo_q) + $past(prod)));

  assert_dacc_hi_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (dacc_fire && !hi_wr_en) |=> $stable(hi_q));

  assert_hi_write_R8: assert property (@(posedge clk) disable iff (rst)
    hi_wr_en |=> (hi_q == $past(wr_data)));

  assert_lo_write_R8: assert property (@(posedge clk) disable iff (rst)
    lo_wr_en |=> (lo_q == $past(wr_data)));

endmodule

// File: tb/hilo_mac_unit_bench.sv
`timescale 1ns/1ps
module hilo_mac_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        insn_valid;
  logic [31:0] insn_word;
  logic [63:0] src_a, src_b;
  logic        hi_wr_en, lo_wr_en;
  logic [63:0] wr_data;
  logic [63:0] hi_q, lo_q;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_hi = '0;
  logic [63:0] m_lo = '0;

  always #2 clk = ~clk;

  hilo_mac_unit u_hilo_mac_unit (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .src_a(src_a), .src_b(src_b), .hi_wr_en(hi_wr_en), .lo_wr_en(lo_wr_en),
    .wr_data(wr_data), .hi_q(hi_q), .lo_q(lo_q)
  );

  localparam int K_NONE = 0, K_ACC = 1, K_DACC = 2;

  function automatic logic [31:0] enc(input logic [5:0] fn, input logic [4:0] rs,
                                      input logic [4:0] rt);
    return {6'b000000, rs, rt, 10'b0, fn};
  endfunction

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
    int sa, sb;
    longint p;
    sa = a;
    sb = b;
    p = longint'(sa) * longint'(sb);
    return p;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " HI"}, hi_q, m_hi);
    chk({tag, " LO"}, lo_q, m_lo);
  endtask

  // One cycle of stimulus; the model applies the expected effect.
  task automatic step(input bit v, input logic [31:0] w, input logic [63:0] a,
                      input logic [63:0] b, input int kind, input bit hw,
                      input bit lw, input logic [63:0] d);
    logic [63:0] p, acc;
    @(negedge clk);
    insn_valid = v; insn_word = w; src_a = a; src_b = b;
    hi_wr_en = hw; lo_wr_en = lw; wr_data = d;
    #1;
    if (v) begin
      chk("R7 no early HI change", hi_q, m_hi);
      chk("R7 no early LO change", lo_q, m_lo);
    end
    @(negedge clk);
    insn_valid = 1'b0; hi_wr_en = 1'b0; lo_wr_en = 1'b0;
    p = ref_prod(a[31:0], b[31:0]);
    if (kind == K_ACC) begin
      acc = {m_hi[31:0], m_lo[31:0]} + p;
      m_hi[31:0] = acc[63:32];
      m_lo[31:0] = acc[31:0];
    end else if (kind == K_DACC) begin
      m_lo = m_lo + p;
    end
    if (hw) m_hi = d;
    if (lw) m_lo = d;
  endtask

  task automatic load(input logic [63:0] h, input logic [63:0] l);
    step(1'b0, '0, '0, '0, K_NONE, 1'b1, 1'b0, h);
    step(1'b0, '0, '0, '0, K_NONE, 1'b0, 1'b1, l);
  endtask

  task automatic t_reset;
    chk_regs("R1 after reset");
    load(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_hi = '0; m_lo = '0;
    chk_regs("R1 reset mid-run");
  endtask

  task automatic t_acc_basic;
    step(1'b1, enc(6'b101000, 5'd3, 5'd4), 64'd7, 64'd6, K_ACC, 0, 0, '0);
    chk_regs("R3 acc 7*6");
    step(1'b1, enc(6'b101000, 5'd1, 5'd2), 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, K_ACC, 0, 0, '0);
    chk_regs("R3 acc -3*5");
    step(1'b1, enc(6'b101000, 5'd9, 5'd9), 64'd0, 64'd0, K_ACC, 0, 0, '0);
    chk("R3 acc 42-15 LO", lo_q, 64'd27);
  endtask

  task automatic t_acc_upper;
    load(64'hDEAD_BEEF_0000_0001, 64'hCAFE_F00D_FFFF_FFFF);
    step(1'b1, enc(6'b101000, 5'd0, 5'd0), 64'd1, 64'd1, K_ACC, 0, 0, '0);
    chk("R3 carry seam HI", hi_q, 64'hDEAD_BEEF_0000_0002);
    chk("R3 carry seam LO", lo_q, 64'hCAFE_F00D_0000_0000);
  endtask

  task automatic t_dacc;
    load(64'h1111_2222_3333_4444, 64'd100);
    step(1'b1, enc(6'b101001, 5'd5, 5'd6), 64'hFFFF_FFFF_FFFF_FFFF, 64'd50, K_DACC, 0, 0, '0);
    chk("R4 dacc LO", lo_q, 64'd50);
    chk("R4 dacc HI kept", hi_q, 64'h1111_2222_3333_4444);
    load(64'h0, 64'h0000_0000_FFFF_FFFF);
    step(1'b1, enc(6'b101001, 5'd5, 5'd6), 64'd1, 64'd1, K_DACC, 0, 0, '0);
    chk("R4 dacc carries past bit 31", lo_q, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_corner;
    load('0, '0);
    step(1'b1, enc(6'b101000, 5'd2, 5'd2), 64'h8000_0000, 64'h8000_0000, K_ACC, 0, 0, '0);
    chk("R9 min squared HI", hi_q, 64'h0000_0000_4000_0000);
    chk("R9 min squared LO", lo_q, 64'h0);
    step(1'b1, enc(6'b101000, 5'd2, 5'd2), 64'h8000_0000, 64'h7FFF_FFFF, K_ACC, 0, 0, '0);
    chk_regs("R9 min*max");
    step(1'b1, enc(6'b101001, 5'd2, 5'd2), 64'hFFFF_FFFF, 64'hFFFF_FFFF, K_DACC, 0, 0, '0);
    chk_regs("R4 -1*-1 dacc");
  endtask

  task automatic t_wrap;
    load(64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_FFFF_FFFF);
    step(1'b1, enc(6'b101000, 5'd1, 5'd1), 64'd1, 64'd1, K_ACC, 0, 0, '0);
    chk("R9 acc wrap HI", hi_q, 64'hAAAA_AAAA_0000_0000);
    chk("R9 acc wrap LO", lo_q, 64'h5555_5555_0000_0000);
    load(64'h7, 64'hFFFF_FFFF_FFFF_FFFE);
    step(1'b1, enc(6'b101001, 5'd1, 5'd1), 64'd3, 64'd1, K_DACC, 0, 0, '0);
    chk("R9 dacc wrap LO", lo_q, 64'd1);
    chk("R9 dacc wrap HI", hi_q, 64'd7);
  endtask

  task automatic t_src_upper;
    load(64'h0, 64'h0);
    step(1'b1, enc(6'b101000, 5'd7, 5'd8), 64'h9876_5432_0000_0003,
         64'hFFFF_0000_0000_0004, K_ACC, 0, 0, '0);
    chk("R6 upper source bits ignored LO", lo_q, 64'd12);
    chk("R6 upper source bits ignored HI", hi_q, 64'd0);
  endtask

  task automatic t_illegal;
    load(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    step(1'b1, enc(6'b101000, 5'd1, 5'd1) | 32'h0000_0040, 64'd9, 64'd9, K_NONE, 0, 0, '0);
    chk_regs("R2 bit 6 set rejected");
    step(1'b1, enc(6'b101001, 5'd1, 5'd1) | 32'h0000_8000, 64'd9, 64'd9, K_NONE, 0, 0, '0);
    chk_regs("R2 bit 15 set rejected");
    step(1'b1, enc(6'b101000, 5'd1, 5'd1) | 32'h0400_0000, 64'd9, 64'd9, K_NONE, 0, 0, '0);
    chk_regs("R2 nonzero opcode rejected");
    step(1'b1, enc(6'b101010, 5'd1, 5'd1), 64'd9, 64'd9, K_NONE, 0, 0, '0);
    chk_regs("R2 other function rejected");
    step(1'b0, enc(6'b101000, 5'd1, 5'd1), 64'd9, 64'd9, K_NONE, 0, 0, '0);
    chk_regs("R5 valid low ignored");
    step(1'b1, enc(6'b101000, 5'd31, 5'd17), 64'd2, 64'd3, K_ACC, 0, 0, '0);
    chk_regs("R2 register fields free");
  endtask

  task automatic t_write_priority;
    load(64'h10, 64'h20);
    step(1'b1, enc(6'b101000, 5'd1, 5'd1), 64'd1, 64'd1, K_ACC, 1, 0, 64'hABCD);
    chk("R8 HI load beats acc", hi_q, 64'hABCD);
    chk("R8 LO still takes acc", lo_q, 64'h21);
    step(1'b1, enc(6'b101001, 5'd1, 5'd1), 64'd4, 64'd4, K_DACC, 0, 1, 64'h77);
    chk("R8 LO load beats dacc", lo_q, 64'h77);
    chk("R8 HI untouched", hi_q, 64'hABCD);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; insn_valid = 1'b0; insn_word = '0; src_a = '0; src_b = '0;
    hi_wr_en = 1'b0; lo_wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_acc_basic();
    t_acc_upper();
    t_dacc();
    t_corner();
    t_wrap();
    t_src_upper();
    t_illegal();
    t_write_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule